// File: doc/BRIEF.md
# USB Serial Line Transmitter

This block drives a USB D+/D- pair at low speed (1.5 Mbit/s) or full speed (12 Mbit/s) from a short command queue that a processor fills. A queue entry carries a data byte, a line-state command, or a delay command. Bytes go out LSB first with NRZI encoding and bit stuffing. A line-state command forces J, K or SE0, or runs an end-of-packet sequence. A delay command keeps the line idle for a given number of bit periods.

Every output change is paced by a bit-clock enable that a programmable divider derives from the system clock. Software can therefore set inter-packet and turnaround gaps in USB bit times and does not have to count processor cycles. A queue-empty flag shows when software may post more work. A sticky flag records any write that was lost because the queue was full.

Top module: `usb_line_tx`

## Requirements
- R1: The bit period is (bit_div+1) system clocks at full speed and 8*(bit_div+1) at low speed. The first bit tick comes that many clocks after reset is released. dp/dm change only at the clock edge of a bit tick.
- R2: Line levels on {dp,dm}: full-speed J is 10 and low-speed J is 01. K is the inverse of J and SE0 is 00. After reset the line sits at J.
- R3: Entry encoding on cmd_kind: 0 is a data byte (cmd_arg[7:0]), 1 is a line command (cmd_arg[1:0]: 0 J, 1 K, 2 SE0, 3 end-of-packet), 2 is a delay of cmd_arg bit periods. Entries run in write order. An entry starts at the first bit tick on which the engine is free, and no earlier than the second clock after its write.
- R4: A data byte is sent LSB first. A 0 bit toggles the line between J and K and a 1 bit holds it. A byte that follows SE0 starts from J.
- R5: After six consecutive 1 bits, one stuffed toggle is sent in the next bit period. The run count carries across back-to-back data bytes and is cleared by any line or delay entry.
- R6: J, K and SE0 line commands take effect on one bit tick and the level then persists until the next entry.
- R7: End-of-packet drives SE0 for two bit periods, then J for one, then leaves the line at J.
- R8: A delay entry of N holds J for N bit periods (N=0 counts as 1) before the next entry starts.
- R9: buf_empty is high when no entry is pending. It falls on the clock after a write. It rises on the tick that moves the last entry into the engine, even while that entry is still being sent.
- R10: The queue holds 4 entries by default. A write while the queue is full is dropped, and overflow goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_full | input | 1 | 1 selects full speed, 0 low speed; change only in reset |
| bit_div | input | DIV_W | Bit-period divider value |
| cmd_valid | input | 1 | Write strobe for one queue entry |
| cmd_kind | input | 2 | Entry type (see R3) |
| cmd_arg | input | 16 | Byte, line code or delay count |
| dp | output | 1 | D+ level |
| dm | output | 1 | D- level |
| buf_empty | output | 1 | No queue entry pending |
| overflow | output | 1 | Sticky lost-write flag |

## Verification
If the divider count or the queue pointers go wrong, the whole sequence of line levels moves in time. This shows up on the first bit period that differs, so the bench records {dp,dm} once per expected tick and compares each entry. If the NRZI level or the stuffing run count goes wrong, the first bad bit appears within one bit period, and every later toggle of that byte inverts. A bad engine-busy decision either runs an entry early, which breaks the end-of-packet or delay length by one period, or leaves buf_empty high while an entry waits. Both show up within one or two bit periods.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

    localparam int ARG_W = 16;

    typedef enum logic [1:0] {
        CMD_DATA  = 2'd0,
        CMD_LINE  = 2'd1,
        CMD_DELAY = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        LC_J   = 2'd0,
        LC_K   = 2'd1,
        LC_SE0 = 2'd2,
        LC_EOP = 2'd3
    } line_code_e;

    typedef enum logic [1:0] {
        LV_J   = 2'd0,
        LV_K   = 2'd1,
        LV_SE0 = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_BYTE  = 2'd1,
        M_EOP   = 2'd2,
        M_DELAY = 2'd3
    } mode_e;

    typedef struct packed {
        cmd_kind_e        kind;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    // A toggle from J gives K and from K gives J; SE0 counts as J.
    function automatic lvl_e nrzi_flip(input lvl_e cur);
        return (cur == LV_K) ? LV_J : LV_K;
    endfunction

    function automatic lvl_e nrzi_norm(input lvl_e cur);
        return (cur == LV_SE0) ? LV_J : cur;
    endfunction

    // {dp,dm} for a level; the polarity depends on speed.
    function automatic logic [1:0] lvl_pins(input lvl_e lv, input logic full);
        logic [1:0] j_pins;
        j_pins = full ? 2'b10 : 2'b01;
        case (lv)
            LV_J:    return j_pins;
            LV_K:    return ~j_pins;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/usb_tx_baud.sv
module usb_tx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             speed_full,
    input  logic [DIV_W-1:0] bit_div,
    output logic             tick
);
    localparam int CW = DIV_W + 3;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Low speed is eight times slower: (div+1)*8-1 = {div,3'b111}.
    assign limit = speed_full ? {3'b000, bit_div} : {bit_div, 3'b111};
    assign tick  = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0) |=> !tick);

endmodule

// File: rtl/usb_tx_queue.sv
module usb_tx_queue
    import usb_tx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  cmd_t wr_entry,
    input  logic rd_en,
    output cmd_t rd_entry,
    output logic empty,
    output logic overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    cmd_t          mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, wr_ok, rd_ok;

    assign full     = (cnt == FULL_CNT);
    assign empty    = (cnt == '0);
    assign wr_ok    = wr_en && !full;
    assign rd_ok    = rd_en && !empty;
    assign rd_entry = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp       <= '0;
            rp       <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_ok) begin
                mem[wp] <= wr_entry;
                wp      <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            end
            if (rd_ok)
                rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
            else if (!wr_ok && rd_ok) cnt <= cnt - 1'b1;
            if (wr_en && full)
                overflow <= 1'b1;
        end
    end

    // R10
    depth_limit_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    // R3
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);

endmodule

// File: rtl/usb_tx_engine.sv
module usb_tx_engine
    import usb_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic q_valid,
    input  cmd_t q_entry,
    output logic q_pop,
    output lvl_e lvl
);
    mode_e            mode, mode_n;
    logic [6:0]       sh, sh_n;
    logic [2:0]       left, left_n;
    logic [2:0]       ones, ones_n;
    logic [ARG_W-1:0] hold, hold_n;
    lvl_e             lvl_n;
    logic             byte_busy, do_bit, bit_v;

    assign byte_busy = (mode == M_BYTE) && (left != '0 || ones == 3'd6);

    always_comb begin
        mode_n = mode;
        sh_n   = sh;
        left_n = left;
        ones_n = ones;
        hold_n = hold;
        lvl_n  = lvl;
        q_pop  = 1'b0;
        do_bit = 1'b0;
        bit_v  = 1'b0;
        if (tick) begin
            if (byte_busy) begin
                if (ones == 3'd6) begin
                    lvl_n  = nrzi_flip(lvl);
                    ones_n = '0;
                end else begin
                    do_bit = 1'b1;
                    bit_v  = sh[0];
                    sh_n   = {1'b0, sh[6:1]};
                    left_n = left - 1'b1;
                end
            end else if (hold != '0) begin
                hold_n = hold - 1'b1;
                lvl_n  = (mode == M_EOP && hold == ARG_W'(2)) ? LV_SE0 : LV_J;
            end else if (q_valid) begin
                q_pop = 1'b1;
                case (q_entry.kind)
                    CMD_DATA: begin
                        mode_n = M_BYTE;
                        do_bit = 1'b1;
                        bit_v  = q_entry.arg[0];
                        sh_n   = q_entry.arg[7:1];
                        left_n = 3'd7;
                    end
                    CMD_LINE: begin
                        ones_n = '0;
                        case (line_code_e'(q_entry.arg[1:0]))
                            LC_J:   begin lvl_n = LV_J;   mode_n = M_IDLE; end
                            LC_K:   begin lvl_n = LV_K;   mode_n = M_IDLE; end
                            LC_SE0: begin lvl_n = LV_SE0; mode_n = M_IDLE; end
                            default: begin
                                lvl_n  = LV_SE0;
                                mode_n = M_EOP;
                                hold_n = ARG_W'(2);
                            end
                        endcase
                    end
                    default: begin
                        ones_n = '0;
                        lvl_n  = LV_J;
                        mode_n = M_DELAY;
                        hold_n = (q_entry.arg == '0) ? '0 : q_entry.arg - 1'b1;
                    end
                endcase
            end
        end
        if (do_bit) begin
            if (bit_v) begin
                lvl_n  = nrzi_norm(lvl);
                ones_n = ones + 1'b1;
            end else begin
                lvl_n  = nrzi_flip(lvl);
                ones_n = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= M_IDLE;
            sh   <= '0;
            left <= '0;
            ones <= '0;
            hold <= '0;
            lvl  <= LV_J;
        end else begin
            mode <= mode_n;
            sh   <= sh_n;
            left <= left_n;
            ones <= ones_n;
            hold <= hold_n;
            lvl  <= lvl_n;
        end
    end

    // R5
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        ones <= 3'd6);
    // R7
    eop_start_chk: assert property (@(posedge clk) disable iff (rst)
        (q_pop && q_entry.kind == CMD_LINE && q_entry.arg[1:0] == 2'd3) |=> lvl == LV_SE0);
    // R8
    delay_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_DELAY && hold != '0) |-> lvl == LV_J);
    // R3
    no_pop_busy_chk: assert property (@(posedge clk) disable iff (rst)
        q_pop |-> (tick && !byte_busy && hold == '0));

endmodule

// File: rtl/usb_line_tx.sv
module usb_line_tx
    import usb_tx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             speed_full,
    input  logic [DIV_W-1:0] bit_div,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic [ARG_W-1:0] cmd_arg,
    output logic             dp,
    output logic             dm,
    output logic             buf_empty,
    output logic             overflow
);
    logic tick, q_empty, q_pop;
    cmd_t wr_entry, rd_entry;
    lvl_e lvl;

    assign wr_entry.kind = cmd_kind_e'(cmd_kind);
    assign wr_entry.arg  = cmd_arg;

    usb_tx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst(rst), .speed_full(speed_full),
        .bit_div(bit_div), .tick(tick)
    );

    usb_tx_queue #(.DEPTH(DEPTH)) queue_i (
        .clk(clk), .rst(rst), .wr_en(cmd_valid), .wr_entry(wr_entry),
        .rd_en(q_pop), .rd_entry(rd_entry), .empty(q_empty),
        .overflow(overflow)
    );

    usb_tx_engine engine_i (
        .clk(clk), .rst(rst), .tick(tick), .q_valid(!q_empty),
        .q_entry(rd_entry), .q_pop(q_pop), .lvl(lvl)
    );

    assign {dp, dm}  = lvl_pins(lvl, speed_full);
    assign buf_empty = q_empty;

    // R1
    pins_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && $stable(speed_full)) |=> $stable({dp, dm}));
    // R9
    empty_falls_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !tick) |=> !buf_empty);

endmodule

// File: tb/usb_line_tx_tb_top.sv
module usb_line_tx_tb_top;
    import usb_tx_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             speed_full = 1'b1;
    logic [7:0]       bit_div = 8'd7;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_kind = 2'd0;
    logic [ARG_W-1:0] cmd_arg = '0;
    logic             dp, dm, buf_empty, overflow;

    int total = 0;
    int bad = 0;

    usb_line_tx dut_i (
        .clk(clk), .rst(rst), .speed_full(speed_full), .bit_div(bit_div),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_arg(cmd_arg),
        .dp(dp), .dm(dm), .buf_empty(buf_empty), .overflow(overflow)
    );

    always #2 clk = ~clk;

    // Bench model of the bit period (R1) and a per-tick log of the line.
    int         period = 8;
    int         bcnt = 0;
    logic       ticked = 1'b0;
    logic [1:0] log_pins [0:511];
    int         log_n = 0;

    always @(posedge clk) begin
        if (rst) begin
            bcnt <= 0; ticked <= 1'b0;
        end else if (bcnt == period - 1) begin
            bcnt <= 0; ticked <= 1'b1;
        end else begin
            bcnt <= bcnt + 1; ticked <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst && ticked && log_n < 512) begin
            log_pins[log_n] = {dp, dm};
            log_n = log_n + 1;
        end
    end

    // Line model: 0 J, 1 K, 2 SE0.
    int exp_lv [0:255];
    int exp_n = 0;
    int m_lvl = 0;
    int m_ones = 0;
    int base = 0;

    function automatic logic [1:0] pins_of(input int lv);
        logic [1:0] j;
        j = speed_full ? 2'b10 : 2'b01;
        if (lv == 2) return 2'b00;
        return (lv == 0) ? j : ~j;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic m_put(input int lv);
        exp_lv[exp_n] = lv;
        exp_n++;
        m_lvl = lv;
    endtask

    task automatic m_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            if (b[i]) begin
                m_put((m_lvl == 2) ? 0 : m_lvl);
                m_ones++;
                if (m_ones == 6) begin
                    m_put((m_lvl == 1) ? 0 : 1);
                    m_ones = 0;
                end
            end else begin
                m_put((m_lvl == 1) ? 0 : 1);
                m_ones = 0;
            end
        end
    endtask

    task automatic send(input int kind, input int arg, input bit model);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_kind  = kind[1:0];
        cmd_arg   = arg[ARG_W-1:0];
        if (model) begin
            m_ones = (kind == 0) ? m_ones : 0;
            if (kind == 0) m_byte(arg[7:0]);
            else if (kind == 1) begin
                if (arg == 3) begin m_put(2); m_put(2); m_put(0); end
                else m_put(arg);
            end else begin
                for (int i = 0; i < ((arg == 0) ? 1 : arg); i++) m_put(0);
            end
        end
    endtask

    task automatic end_batch();
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset(input logic full, input logic [7:0] div);
        @(negedge clk);
        rst = 1'b1;
        speed_full = full;
        bit_div = div;
        period = full ? (div + 1) : 8 * (div + 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_lvl = 0; m_ones = 0; exp_n = 0;
    endtask

    task automatic begin_batch();
        @(negedge clk);
        while (!ticked) @(negedge clk);
        #1;
        base = log_n;
        exp_n = 0;
    endtask

    task automatic check_run(input string req, input int extra);
        int need;
        int first_bad;
        logic [1:0] e;
        need = exp_n + extra;
        while (log_n < base + need) @(negedge clk);
        #1;
        first_bad = -1;
        for (int i = 0; i < need; i++) begin
            e = pins_of((i < exp_n) ? exp_lv[i] : m_lvl);
            if (first_bad < 0 && log_pins[base + i] !== e) first_bad = i;
        end
        total++;
        if (first_bad >= 0) begin
            bad++;
            $display("FAIL %s line bit %0d actual=%b expected=%b", req, first_bad,
                     log_pins[base + first_bad],
                     pins_of((first_bad < exp_n) ? exp_lv[first_bad] : m_lvl));
        end
    endtask

    // R2 R9 R10: reset state at both speeds
    task automatic t_reset();
        do_reset(1'b1, 8'd7);
        @(negedge clk);
        check("R2", "fs idle pins", {30'd0, dp, dm}, 32'b10);
        check("R9", "empty after reset", buf_empty, 1);
        check("R10", "overflow after reset", overflow, 0);
        do_reset(1'b0, 8'd1);
        @(negedge clk);
        check("R2", "ls idle pins", {30'd0, dp, dm}, 32'b01);
    endtask

    // R1 R6: a K waits for the next tick, then persists
    task automatic t_tick_align();
        do_reset(1'b1, 8'd7);
        begin_batch();
        send(1, 1, 1);
        end_batch();
        while (bcnt != period - 1) @(negedge clk);
        check("R1", "line before tick", {30'd0, dp, dm}, 32'b10);
        check_run("R6", 3);
    endtask

    // R4 R7: plain bytes then end of packet, full speed
    task automatic t_bytes_fs();
        do_reset(1'b1, 8'd7);
        begin_batch();
        send(0, 8'h00, 1);
        send(0, 8'hA5, 1);
        send(1, 3, 1);
        end_batch();
        check_run("R4", 0);
        check_run("R7", 3);
    endtask

    // R5: stuffing inside a byte, across bytes, and cleared by a line entry
    task automatic t_stuff();
        do_reset(1'b1, 8'd7);
        begin_batch();
        send(0, 8'hFF, 1);
        send(0, 8'h80, 1);
        send(0, 8'h3F, 1);
        send(1, 3, 1);
        end_batch();
        check_run("R5", 2);
        begin_batch();
        send(0, 8'hF8, 1);
        send(1, 0, 1);
        send(0, 8'h01, 1);
        end_batch();
        check_run("R5", 2);
    endtask

    // R2 R6 R4: line commands and a byte after SE0, low speed
    task automatic t_line_ls();
        do_reset(1'b0, 8'd1);
        begin_batch();
        send(1, 1, 1);
        send(1, 2, 1);
        send(0, 8'hC3, 1);
        send(1, 2, 1);
        end_batch();
        check_run("R6", 3);
        @(negedge clk);
        check("R2", "ls se0 held", {30'd0, dp, dm}, 32'b00);
    endtask

    // R8: gap after end of packet, and zero-length delay
    task automatic t_delay();
        do_reset(1'b1, 8'd7);
        begin_batch();
        send(1, 3, 1);
        send(2, 5, 1);
        send(0, 8'h00, 1);
        end_batch();
        check_run("R8", 1);
        begin_batch();
        send(1, 1, 1);
        send(2, 0, 1);
        send(1, 1, 1);
        end_batch();
        check_run("R8", 2);
    endtask

    // R9: empty falls after write, rises when the entry is taken
    task automatic t_empty();
        do_reset(1'b1, 8'd7);
        begin_batch();
        send(0, 8'h00, 1);
        end_batch();
        check("R9", "empty after write", buf_empty, 0);
        while (log_n < base + 1) @(negedge clk);
        #1;
        check("R9", "empty once taken", buf_empty, 1);
        check_run("R9", 1);
    endtask

    // R10: fifth write into a full queue is dropped
    task automatic t_overflow();
        do_reset(1'b0, 8'd1);
        begin_batch();
        send(1, 1, 1);
        send(1, 0, 1);
        send(1, 1, 1);
        send(1, 2, 1);
        send(1, 1, 0);
        end_batch();
        check("R10", "overflow set", overflow, 1);
        check_run("R10", 3);
        check("R10", "overflow sticky", overflow, 1);
        do_reset(1'b0, 8'd1);
        @(negedge clk);
        check("R10", "overflow cleared", overflow, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_tick_align();
        t_bytes_fs();
        t_stuff();
        t_line_ls();
        t_delay();
        t_empty();
        t_overflow();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule